// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block holds a fixed configuration image and shifts it out, one bit per rising edge of the configuration clock, to a programmable-logic device that is loading itself. It needs no controller of its own. The loading device steers it with three signals: an output-enable line that doubles as a restart, an active-low select, and the configuration clock. The image is a parameter laid out as `DEPTH` words of `WORD_W` bits. The stream may stop part-way through the last word, at `TOTAL_BITS`.

When power is applied, a reset sequence holds the block idle for `POR_CYCLES` clock edges. During that time an open-drain ready indicator is pulled low. When the sequence ends, the block is positioned at the first bit of the image. Pulling the output-enable line low returns the block to the first bit and floats the serial output, whatever the select line is doing. The block shifts only while output-enable is high and select is low. Once the last bit has gone out, the block floats its serial output and pulls its cascade output low, so that a following device can take over the shared data line. It stays in that state until the next restart.

The tri-state data pin and the open-drain ready pin are each modelled as a value plus a drive enable.

Top module: `cfg_bitstream_reader`

## Requirements
- R1: After `rst_n` is released, `ready_oe` is 1 and `ready_o` is 0 for exactly `POR_CYCLES` rising `dclk` edges. After that, `ready_oe` is 0 and stays 0 until the next `rst_n` assertion.
- R2: While `ready_oe` is 1, `data_oe` is 0 and the stream position does not advance, even with `oe`=1 and `cs_n`=0.
- R3: When the power-up sequence ends, the first bit presented is bit 0 of the stream, without any `oe` pulse.
- R4: Stream bit k is bit `WORD_W-1-(k mod WORD_W)` of word `k/WORD_W`, and word i is `MEM_INIT[i*WORD_W +: WORD_W]`, so each word goes out MSB first. While `oe`=1, `cs_n`=0 and the stream is unfinished, `data_oe`=1, `data_o` shows the current bit, and each rising `dclk` moves to the next bit.
- R5: With `oe`=1 and `cs_n`=1, `data_oe` is 0 and the position holds. When `cs_n` returns low, the stream continues at the bit where it stopped.
- R6: While `oe`=0, `data_oe` is 0 whatever the value of `cs_n`. A rising `dclk` edge with `oe`=0 returns the position to stream bit 0.
- R7: After `TOTAL_BITS` bits have been presented, `casc_n` is 0 and `data_oe` is 0. The position holds while `oe` stays 1.
- R8: `casc_n` is 1 before the stream finishes. A rising `dclk` edge with `oe`=0 sets `casc_n` back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Configuration clock; the stream advances on its rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| oe | input | 1 | Output enable; a low level restarts the stream |
| cs_n | input | 1 | Select, active low; lets the stream run |
| data_o | output | 1 | Current serial bit value |
| data_oe | output | 1 | Drive enable for the serial data pin |
| casc_n | output | 1 | Low once the stream is complete |
| ready_o | output | 1 | Open-drain ready value, always 0 |
| ready_oe | output | 1 | Pull-down enable for the ready pin; 1 during power-up |

## Verification
On every cycle, the assertions check the following:
- the ready pull-down and the serial drive are never on together;
- the cascade output and the serial drive are never active together;
- a restart edge lands on stream bit 0;
- an idle cycle leaves the position unchanged;
- the word address only ever moves forward by one;
- the ready line, once released, is not pulled low again.

Only the bench's scenarios can show the following:
- the actual bit values and their MSB-first order across a word boundary;
- the exact length of the power-up hold;
- resuming at the same bit after select goes high;
- the hand-off after a stream that ends part-way through a word.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   typedef enum logic [1:0] {
      PWR_HOLD = 2'b01,
      PWR_RUN  = 2'b10
   } pwr_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cbr_rom.sv
module cbr_rom #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter logic [WORD_W*DEPTH-1:0] MEM_INIT = '0,
   localparam int unsigned AW = cbr_pkg::idx_width(DEPTH)
) (
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      assign cells[g] = MEM_INIT[g*WORD_W +: WORD_W];
   end

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign rd_word = cells[rd_addr];
   end else begin : g_npow2
      always_comb begin
         rd_word = '0;
         if (int'(rd_addr) < DEPTH) rd_word = cells[rd_addr];
      end
   end

endmodule

// File: rtl/cbr_por.sv
module cbr_por #(
   parameter int unsigned POR_CYCLES = 16,
   localparam int unsigned CW = cbr_pkg::idx_width(POR_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic por_done
);
   import cbr_pkg::*;

   pwr_state_t state;

   if (POR_CYCLES == 0) begin : g_instant
      assign state    = PWR_RUN;
      assign por_done = 1'b1;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);
      logic [CW-1:0] cnt;
      pwr_state_t    st_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= PWR_HOLD;
            cnt  <= '0;
         end else if (st_q == PWR_HOLD) begin
            if (cnt == LAST) st_q <= PWR_RUN;
            else             cnt  <= cnt + 1'b1;
         end
      end

      assign state    = st_q;
      assign por_done = (st_q == PWR_RUN);

      AST_POR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= LAST); // R1
      AST_POR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(st_q)); // R1
   end

   logic unused_state;
   assign unused_state = ^state;

endmodule

// File: rtl/cbr_walk.sv
module cbr_walk #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned TOTAL_BITS = 128,
   localparam int unsigned AW = cbr_pkg::idx_width(DEPTH),
   localparam int unsigned BW = cbr_pkg::idx_width(WORD_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          advance,
   output logic [AW-1:0] addr,
   output logic [BW-1:0] bitpos,
   output logic          finished
);

   localparam logic [AW-1:0] FIN_ADDR = AW'((TOTAL_BITS - 1) / WORD_W);
   localparam logic [BW-1:0] FIN_BIT  = BW'((TOTAL_BITS - 1) % WORD_W);
   localparam logic [BW-1:0] TOP_BIT  = BW'(WORD_W - 1);

   logic at_final;
   logic at_word_end;

   assign at_final    = (addr == FIN_ADDR) && (bitpos == FIN_BIT);
   assign at_word_end = (bitpos == TOP_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         bitpos   <= '0;
         finished <= 1'b0;
      end else if (restart) begin
         addr     <= '0;
         bitpos   <= '0;
         finished <= 1'b0;
      end else if (advance && !finished) begin
         if (at_final) begin
            finished <= 1'b1;
         end else if (at_word_end) begin
            bitpos <= '0;
            addr   <= addr + 1'b1;
         end else begin
            bitpos <= bitpos + 1'b1;
         end
      end
   end

   AST_RESTART_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (addr == '0 && bitpos == '0 && !finished)); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !advance) |=> ($stable(addr) && $stable(bitpos) && $stable(finished))); // R5
   AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && advance) |=> (addr == $past(addr) || addr == $past(addr) + 1'b1)); // R4
   AST_FINISH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (finished && !restart) |=> (finished && $stable(addr) && $stable(bitpos))); // R7
   AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitpos <= TOP_BIT); // R4

endmodule

// File: rtl/cfg_bitstream_reader.sv
module cfg_bitstream_reader #(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned TOTAL_BITS = 128,
   parameter int unsigned POR_CYCLES = 16,
   parameter logic [WORD_W*DEPTH-1:0] MEM_INIT = {4{32'h5AC3_1E97}}
) (
   input  logic dclk,
   input  logic rst_n,
   input  logic oe,
   input  logic cs_n,
   output logic data_o,
   output logic data_oe,
   output logic casc_n,
   output logic ready_o,
   output logic ready_oe
);

   localparam int unsigned AW = cbr_pkg::idx_width(DEPTH);
   localparam int unsigned BW = cbr_pkg::idx_width(WORD_W);

   if (WORD_W < 1)                   begin : g_bad_w   $error("WORD_W must be at least 1");       end
   if (DEPTH < 1)                    begin : g_bad_d   $error("DEPTH must be at least 1");        end
   if (TOTAL_BITS < 1)               begin : g_bad_t0  $error("TOTAL_BITS must be at least 1");   end
   if (TOTAL_BITS > WORD_W * DEPTH)  begin : g_bad_t   $error("TOTAL_BITS exceeds the image");    end

   logic          por_done;
   logic          restart;
   logic          running;
   logic          finished;
   logic [AW-1:0] addr;
   logic [BW-1:0] bitpos;
   logic [WORD_W-1:0] cur_word;

   cbr_por #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk      (dclk),
      .rst_n    (rst_n),
      .por_done (por_done)
   );

   assign restart = !por_done || !oe;
   assign running = por_done && oe && !cs_n && !finished;

   cbr_walk #(
      .WORD_W     (WORD_W),
      .DEPTH      (DEPTH),
      .TOTAL_BITS (TOTAL_BITS)
   ) u_walk (
      .clk      (dclk),
      .rst_n    (rst_n),
      .restart  (restart),
      .advance  (running),
      .addr     (addr),
      .bitpos   (bitpos),
      .finished (finished)
   );

   cbr_rom #(
      .WORD_W   (WORD_W),
      .DEPTH    (DEPTH),
      .MEM_INIT (MEM_INIT)
   ) u_rom (
      .rd_addr (addr),
      .rd_word (cur_word)
   );

   if (WORD_W == 1) begin : g_single
      assign data_o = cur_word[0];
      logic unused_bit;
      assign unused_bit = ^bitpos;
   end else begin : g_msb_first
      assign data_o = cur_word[BW'(WORD_W - 1) - bitpos];
   end

   assign data_oe  = running;
   assign casc_n   = !finished;
   assign ready_o  = 1'b0;
   assign ready_oe = !por_done;

   AST_QUIET_IN_POR: assert property (@(posedge dclk) disable iff (!rst_n)
      ready_oe |-> !data_oe); // R2
   AST_HANDOFF_QUIET: assert property (@(posedge dclk) disable iff (!rst_n)
      !casc_n |-> !data_oe); // R7
   AST_READY_STAYS_OFF: assert property (@(posedge dclk) disable iff (!rst_n)
      !ready_oe |=> !ready_oe); // R1
   AST_POR_NO_CASC: assert property (@(posedge dclk) disable iff (!rst_n)
      ready_oe |-> casc_n); // R8

endmodule

// File: tb/sim_cfg_bitstream_reader.sv
module sim_cfg_bitstream_reader;

   localparam int unsigned W   = 8;
   localparam int unsigned D   = 4;
   localparam int unsigned TOT = 28;
   localparam int unsigned POR = 5;
   localparam logic [W*D-1:0] IMG = 32'hA5C3_0F96;

   typedef struct {
      int   req;
      logic d_oe;
      logic d;
      logic casc;
      logic r_oe;
   } item_t;

   logic dclk = 1'b0;
   logic rst_n = 1'b0;
   logic oe = 1'b1;
   logic cs_n = 1'b0;
   logic data_o, data_oe, casc_n, ready_o, ready_oe;

   int compared = 0;
   int mismatched = 0;
   bit finished_run = 0;
   item_t q[$];

   always #5 dclk = ~dclk;

   cfg_bitstream_reader #(
      .WORD_W(W), .DEPTH(D), .TOTAL_BITS(TOT), .POR_CYCLES(POR), .MEM_INIT(IMG)
   ) u0 (
      .dclk(dclk), .rst_n(rst_n), .oe(oe), .cs_n(cs_n),
      .data_o(data_o), .data_oe(data_oe), .casc_n(casc_n),
      .ready_o(ready_o), .ready_oe(ready_oe)
   );

   function automatic logic img_bit(input int k);
      return IMG[(k / W) * W + (W - 1 - (k % W))];
   endfunction

   task automatic tick();
      @(negedge dclk);
      #1;
   endtask

   task automatic push(input int req, input logic d_oe, input logic d,
                       input logic casc, input logic r_oe);
      item_t it;
      it.req = req; it.d_oe = d_oe; it.d = d; it.casc = casc; it.r_oe = r_oe;
      q.push_back(it);
   endtask

   task automatic run_bits(input int first, input int last, input int req);
      for (int k = first; k <= last; k++) begin
         push(req, 1'b1, img_bit(k), 1'b1, 1'b0);
         tick();
      end
   endtask

   task automatic quiet(input int n, input int req, input logic casc);
      for (int i = 0; i < n; i++) begin
         push(req, 1'b0, 1'b0, casc, 1'b0);
         tick();
      end
   endtask

   // monitor: compares queued expectations in the middle of the low phase
   always begin
      @(negedge dclk);
      #3;
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         compared++;
         if (data_oe !== it.d_oe || casc_n !== it.casc || ready_oe !== it.r_oe
             || ready_o !== 1'b0 || (it.d_oe && data_o !== it.d)) begin
            mismatched++;
            $display("FAIL R%0d: got oe=%b d=%b casc=%b rdy_oe=%b rdy=%b exp oe=%b d=%b casc=%b rdy_oe=%b rdy=0",
                     it.req, data_oe, data_o, casc_n, ready_oe, ready_o,
                     it.d_oe, it.d, it.casc, it.r_oe);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished_run) begin
         mismatched++;
         $display("FAIL R1: watchdog expired, got running exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      tick();
      push(1, 1'b0, 1'b0, 1'b1, 1'b1);          // R1 reset state: ready pulled low
      tick();
      rst_n = 1'b1;
      for (int i = 0; i < POR; i++) begin       // R1 R2 hold for POR edges, no drive
         push(2, 1'b0, 1'b0, 1'b1, 1'b1);
         tick();
      end
      run_bits(0, 9, 3);                        // R3 starts at bit 0; R4 order
      cs_n = 1'b1;
      quiet(3, 5, 1'b1);                        // R5 deselect holds
      cs_n = 1'b0;
      run_bits(10, TOT - 1, 4);                 // R4 across word boundary, partial last word
      quiet(3, 7, 1'b0);                        // R7 hand-off: floated, cascade low
      oe = 1'b0;
      quiet(1, 6, 1'b0);                        // R6 oe low floats data
      oe = 1'b1;
      run_bits(0, 4, 8);                        // R8 cascade released, restart at bit 0
      oe = 1'b0;
      quiet(1, 6, 1'b1);                        // R6 oe low mid-stream with cs_n low
      oe = 1'b1;
      run_bits(0, 2, 6);                        // R6 restarted from bit 0
      oe = 1'b0; cs_n = 1'b1;
      quiet(1, 6, 1'b1);                        // R6 oe low with cs_n high
      oe = 1'b1;
      quiet(2, 5, 1'b1);                        // R5 deselected after restart stays quiet
      cs_n = 1'b0;
      run_bits(0, TOT - 1, 4);                  // R4 full stream again
      quiet(2, 7, 1'b0);                        // R7 end of stream again
      tick();
      tick();
      finished_run = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule